// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution unit works on a single bit of a 16-bit or 32-bit operand. A bit position picks that bit. The unit copies the bit's value, as it was before the operation, into the carry flag. The operation code then decides what happens to the bit: it stays as it is, it is forced to one, it is forced to zero, or it is inverted. The modified operand comes back together with a write-enable. The write-enable tells the register file or the memory stage whether it must store the operand again.

The operand size picks how many low bits of the position are used, so the position wraps inside the operand. Carry is the only status flag this unit defines. A six-bit flag-valid mask marks carry as valid and the other five status flags as undefined. All outputs are registered and appear one clock after the input strobe.

Top module: `bit_modify_unit`

## Requirements
- R1: With op code 0 (test only), the result equals the operand and wr_en stays low.
- R2: With op code 1 (set), the selected bit of the result is 1 and wr_en is high.
- R3: With op code 2 (clear), the selected bit of the result is 0 and wr_en is high.
- R4: With op code 3 (invert), the selected bit of the result is the inverse of the operand's bit and wr_en is high.
- R5: The carry output equals the selected bit of the operand as it was before the operation.
- R6: The bit position is reduced modulo the operand width. When wide is 0 (16-bit), only bit_pos[3:0] counts. When wide is 1 (32-bit), only bit_pos[4:0] counts. All higher position bits have no effect.
- R7: In 16-bit mode, result bits 31:16 equal operand bits 31:16 for every op code.
- R8: Every result bit other than the selected one equals the matching operand bit.
- R9: out_valid is high exactly one cycle after in_valid. In a cycle without a strobe, out_valid and wr_en are low, and result and carry keep their last values.
- R10: flag_valid bit 0 (carry) equals out_valid, and flag_valid bits 5:1 are always 0.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| op | input | 2 | 0 test, 1 set, 2 clear, 3 invert |
| wide | input | 1 | 1: 32-bit operand, 0: 16-bit operand |
| operand | input | DATA_W | Operand value |
| bit_pos | input | POS_W | Bit position, reduced modulo the width |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | DATA_W | Modified operand |
| wr_en | output | 1 | Write-back request |
| carry | output | 1 | Prior value of the selected bit |
| flag_valid | output | 6 | Flag-defined mask, bit 0 is carry |

## Verification
A wrong bit index shows up in the very next result. Carry would report a neighbouring bit, or a bit outside the selected one would change. Checking every position, including positions above the operand width, catches a wrong modulo. A wrong op decode or a mistake in the write-enable shows up at the output one cycle after the strobe. A stale valid or write-enable shows up in the first idle cycle that follows.

// File: rtl/bit_modify_unit.sv
module bit_modify_unit #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 6,
  parameter int NFLAGS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  input  logic [POS_W-1:0]  bit_pos,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              carry,
  output logic [NFLAGS-1:0] flag_valid
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] nxt;
  logic              old_bit;

  assign idx     = wide ? bit_pos[IDX_W-1:0] : {1'b0, bit_pos[IDX_W-2:0]};
  assign sel     = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  assign old_bit = |(operand & sel);

  always_comb begin
    case (op)
      2'd1:    nxt = operand | sel;
      2'd2:    nxt = operand & ~sel;
      2'd3:    nxt = operand ^ sel;
      default: nxt = operand;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      wr_en      <= 1'b0;
      carry      <= 1'b0;
      flag_valid <= '0;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= in_valid && (op != 2'd0);
      flag_valid <= {{(NFLAGS-1){1'b0}}, in_valid};
      if (in_valid) begin
        result <= nxt;
        carry  <= old_bit;
      end
    end
  end
endmodule

// File: rtl/bit_modify_unit_chk.sv
module bit_modify_unit_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 6,
  parameter int NFLAGS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic              wide,
  input logic [DATA_W-1:0] operand,
  input logic [POS_W-1:0]  bit_pos,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              carry,
  input logic [NFLAGS-1:0] flag_valid
);
  logic [POS_W-1:0]  pm;
  logic [DATA_W-1:0] bm;
  assign pm = wide ? bit_pos % POS_W'(DATA_W) : bit_pos % POS_W'(DATA_W/2);
  assign bm = DATA_W'(1) << pm;

  AST_TEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0) |=> (result == $past(operand) && !wr_en)); // R1
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1) |=> ((result & $past(bm)) != 0 && wr_en)); // R2
  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2) |=> ((result & $past(bm)) == 0 && wr_en)); // R3
  AST_INVERT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> (((result ^ $past(operand)) & $past(bm)) != 0 && wr_en)); // R4
  AST_CARRY_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (carry == ((($past(operand) & $past(bm)) != 0)))); // R5
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((result ^ $past(operand)) & ~$past(bm)) == 0)); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && $stable(result) && $stable(carry))); // R9
  AST_FLAG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid == {{(NFLAGS-1){1'b0}}, out_valid}); // R10
endmodule

bind bit_modify_unit bit_modify_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W), .NFLAGS(NFLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
  .operand(operand), .bit_pos(bit_pos), .out_valid(out_valid), .result(result),
  .wr_en(wr_en), .carry(carry), .flag_valid(flag_valid)
);

// File: tb/bit_modify_unit_test.sv
`timescale 1ns/1ps
module bit_modify_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        wide = 1'b0;
  logic [31:0] operand = '0;
  logic [5:0]  bit_pos = '0;
  logic        out_valid, wr_en, carry;
  logic [31:0] result;
  logic [5:0]  flag_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bit_modify_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .operand(operand), .bit_pos(bit_pos), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .carry(carry), .flag_valid(flag_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input int w, input int o, input int p, input logic [31:0] val);
    int idx;
    logic [31:0] exp_r;
    logic exp_c;
    idx   = (w != 0) ? (p % 32) : (p % 16);
    exp_c = val[idx];
    exp_r = val;
    if (o == 1) exp_r[idx] = 1'b1;
    if (o == 2) exp_r[idx] = 1'b0;
    if (o == 3) exp_r[idx] = ~val[idx];
    @(negedge clk);
    in_valid = 1'b1; op = 2'(o); wide = w[0]; operand = val; bit_pos = 6'(p);
    @(negedge clk);
    in_valid = 1'b0;
    operand = ~val;
    check(result == exp_r, (o == 0) ? "R1" : (o == 1) ? "R2" : (o == 2) ? "R3" : "R4", result, exp_r);
    check(wr_en == (o != 0), "R1 wr_en", {31'd0, wr_en}, {31'd0, o != 0});
    check(carry == exp_c, "R5 R6", {31'd0, carry}, {31'd0, exp_c});
    check((result & ~(32'd1 << idx)) == (val & ~(32'd1 << idx)), "R8", result, val);
    if (w == 0)
      check(result[31:16] == val[31:16], "R7", {16'd0, result[31:16]}, {16'd0, val[31:16]});
    check(out_valid == 1'b1, "R9 valid", {31'd0, out_valid}, 32'd1);
    check(flag_valid == 6'b000001, "R10", {26'd0, flag_valid}, 32'd1);
    @(negedge clk);
    check(out_valid == 1'b0 && wr_en == 1'b0, "R9 idle", {30'd0, out_valid, wr_en}, 32'd0);
    check(result == exp_r && carry == exp_c, "R9 hold", result, exp_r);
    check(flag_valid == 6'b000000, "R10 idle", {26'd0, flag_valid}, 32'd0);
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5C3_96F0;
    #1;
    check(out_valid == 0 && result == 0 && wr_en == 0 && carry == 0 && flag_valid == 0,
          "R11", result, 32'd0);
    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == 0 && wr_en == 0 && carry == 0 && flag_valid == 0,
          "R11 held", result, 32'd0);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 3; k++)
          for (int p = 0; p < 64; p++)
            run_one(w, o, p, pats[k] ^ (32'h0101_0101 * 32'(p)));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule